// File: doc/BRIEF.md
# I2C Interactive Receive Data Path

This block is the receive-side data path of an I2C controller. Completed bytes arrive from the bit-level shifter as a one-cycle strobe, together with the byte value and a tag that says what kind of byte it is. In normal operation, data bytes go into an 8-entry RX FIFO. Software drains that FIFO through a small register bus, and it fills an 8-entry TX FIFO through the same bus. Each FIFO has its own DMA request line, raised by comparing the FIFO's count with a programmable threshold.

The block also has an interactive receive mode. In this mode every received data byte stays in a holding register and never reaches the RX FIFO. The block raises a flag and asks the bit engine to stretch SCL until software clears the flag. While the flag is pending, software reads the byte through the data register. It may then turn the mode off and, as a master, load how many bytes are still to come. The rest of the transfer then runs through the FIFO. The byte that brings the remaining count to zero is marked to be answered with NACK. If software turns the mode off without reading the held byte, the next data read returns 0xFF.

A three-state machine drives the flag and the stretch request:
- IDLE goes to HOLD when an interactive data byte arrives.
- HOLD goes to RELEASE when software writes one to the flag bit.
- RELEASE goes to HOLD if another interactive data byte arrives, and otherwise to IDLE.

The flag is high only in HOLD. The stretch request is high in HOLD and RELEASE.

Top module: `i2c_irx_path`

## Requirements
- R1: After reset the flag, stretch request and NACK mark are 0 and interactive mode is off. The RX threshold is 1 and the TX threshold is 0, so `rx_dma_req` is 0 and `tx_dma_req` is 1.
- R2: With interactive mode on (CTRL, address 1, bit 0), a data byte (`byte_kind` 1) sets `irq_flag` and `scl_hold` in the cycle after the strobe. The byte is not written into the RX FIFO.
- R3: While interactive mode is on, a read of DATA (address 0) returns the byte held from the shifter.
- R4: The flag is bit 0 of STAT (address 2) and is write-one-to-clear. Writing 0 leaves it set. `scl_hold` stays high for one cycle after the flag clears, then drops.
- R5: Address (kind 0), general call (kind 2) and START-byte (kind 3) strobes never set the flag or the stretch request, and they are not stored in the RX FIFO.
- R6: Suppose interactive mode is turned off while the held byte is unread. The next DATA read then returns 0xFF, once, and the reads after it use the FIFO again.
- R7: With interactive mode off, data bytes enter the RX FIFO and DATA reads return them in arrival order. A DATA read of an empty FIFO returns 0x00 and sets STAT bit 1, which is also write-one-to-clear.
- R8: With `is_master` high, a write to REMAIN (address 4) loads the remaining-byte count, and each data byte decrements it while it is nonzero. `nack_next` is high while the count is 1 in master mode.
- R9: `tx_dma_req` is high whenever the TX FIFO count is less than or equal to the TX threshold (THR, address 3, bits 7:4). DATA writes push the TX FIFO.
- R10: `rx_dma_req` is high whenever the RX FIFO count is greater than or equal to the RX threshold (THR bits 3:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_done | input | 1 | One-cycle strobe: a byte has completed |
| byte_kind | input | 2 | 0 address, 1 data, 2 general call, 3 START byte |
| byte_data | input | 8 | Value of the completed byte |
| is_master | input | 1 | Controller is running as master |
| tx_pop | input | 1 | Bit engine consumes the TX FIFO head |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (DATA reads have side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_flag | output | 1 | Interactive byte is pending |
| scl_hold | output | 1 | Request to the bit engine to stretch SCL |
| nack_next | output | 1 | Next data byte is to be answered with NACK |
| tx_data | output | 8 | TX FIFO head for the bit engine |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The assertions assume that the shifter never completes a data byte while the flag is pending, because the stretch request holds the bus. They also assume that the FIFOs are never pushed when full or popped when empty from outside the block. The stimulus delivers data bytes only after the flag has been cleared, keeps both FIFO fills at or below eight, and raises `tx_pop` only when a TX byte is present. Under those conditions the checks on flag timing, the FIFO bypass and the remaining-count countdown describe the block's own behaviour rather than illegal traffic.

// File: rtl/irx_pkg.sv
package irx_pkg;
    typedef enum logic [1:0] {
        KIND_ADDR  = 2'd0,
        KIND_DATA  = 2'd1,
        KIND_GCALL = 2'd2,
        KIND_START = 2'd3
    } byte_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2
    } irx_state_t;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_THR  = 3'd3;
    localparam logic [2:0] A_REM  = 3'd4;
endpackage

// File: rtl/irx_fifo.sv
module irx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  pdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push && !full) wptr <= wptr + 1'b1;
            if (pop && !empty) rptr <= rptr + 1'b1;
            unique case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wptr] <= pdata;
    end

    assign head  = mem[rptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/irx_fsm.sv
module irx_fsm
    import irx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_byte,
    input  logic flag_clr,
    output logic flag,
    output logic scl_hold
);
    irx_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (hold_byte) nxt = ST_HOLD;
            ST_HOLD:    if (flag_clr)  nxt = ST_RELEASE;
            ST_RELEASE: nxt = hold_byte ? ST_HOLD : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        flag     = (state == ST_HOLD);
        scl_hold = (state != ST_IDLE);
    end

    p_hold_covers_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> scl_hold);
    p_release_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> scl_hold);
    p_no_byte_while_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> !hold_byte);
endmodule

// File: rtl/i2c_irx_path.sv
module i2c_irx_path
    import irx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int REM_W = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_done,
    input  logic [1:0] byte_kind,
    input  logic [7:0] byte_data,
    input  logic       is_master,
    input  logic       tx_pop,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_flag,
    output logic       scl_hold,
    output logic       nack_next,
    output logic [7:0] tx_data,
    output logic       tx_dma_req,
    output logic       rx_dma_req
);
    logic             irx_en, held_unread, ff_arm, underflow;
    logic [7:0]       held;
    logic [CW-1:0]    rx_thr, tx_thr, rx_cnt, tx_cnt;
    logic [REM_W-1:0] remain;
    logic [7:0]       rx_head;
    logic             rx_empty, rx_full, tx_empty, tx_full;

    logic is_data, hold_byte, rx_push, data_rd, rx_pop, tx_push, flag_clr, rem_load;
    assign is_data   = byte_done && (byte_kind == KIND_DATA);
    assign hold_byte = is_data && irx_en;
    assign rx_push   = is_data && !irx_en;
    assign data_rd   = reg_rd && (reg_addr == A_DATA);
    assign rx_pop    = data_rd && !irx_en && !ff_arm && !rx_empty;
    assign tx_push   = reg_wr && (reg_addr == A_DATA) && !tx_full;
    assign flag_clr  = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];
    assign rem_load  = reg_wr && (reg_addr == A_REM) && is_master;

    irx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hold_byte(hold_byte), .flag_clr(flag_clr),
        .flag(irq_flag), .scl_hold(scl_hold)
    );

    irx_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pdata(byte_data), .pop(rx_pop),
        .head(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    irx_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pdata(reg_wdata),
        .pop(tx_pop && !tx_empty),
        .head(tx_data), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irx_en      <= 1'b0;
            held        <= 8'h00;
            held_unread <= 1'b0;
            ff_arm      <= 1'b0;
            underflow   <= 1'b0;
            rx_thr      <= CW'(1);
            tx_thr      <= '0;
            remain      <= '0;
        end else begin
            if (hold_byte) begin
                held        <= byte_data;
                held_unread <= 1'b1;
            end else if (data_rd && irx_en) begin
                held_unread <= 1'b0;
            end
            if (reg_wr && reg_addr == A_CTRL) begin
                irx_en <= reg_wdata[0];
                if (irx_en && !reg_wdata[0] && held_unread) begin
                    ff_arm      <= 1'b1;
                    held_unread <= 1'b0;
                end
            end
            if (data_rd && !irx_en && ff_arm) ff_arm <= 1'b0;
            if (data_rd && !irx_en && !ff_arm && rx_empty) underflow <= 1'b1;
            else if (reg_wr && reg_addr == A_STAT && reg_wdata[1]) underflow <= 1'b0;
            if (reg_wr && reg_addr == A_THR) begin
                rx_thr <= CW'(reg_wdata[3:0]);
                tx_thr <= CW'(reg_wdata[7:4]);
            end
            if (rem_load)                     remain <= REM_W'(reg_wdata);
            else if (is_data && remain != '0) remain <= remain - 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_DATA:  reg_rdata = irx_en ? held : (ff_arm ? 8'hFF : (rx_empty ? 8'h00 : rx_head));
            A_CTRL:  reg_rdata = {7'b0, irx_en};
            A_STAT:  reg_rdata = {6'b0, underflow, irq_flag};
            A_THR:   reg_rdata = {4'(tx_thr), 4'(rx_thr)};
            A_REM:   reg_rdata = 8'(remain);
            default: reg_rdata = 8'h00;
        endcase
    end

    assign nack_next  = is_master && (remain == REM_W'(1));
    assign tx_dma_req = (tx_cnt <= tx_thr);
    assign rx_dma_req = (rx_cnt >= rx_thr);

    p_bypass_fifo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_byte |=> $stable(rx_cnt));
    p_other_kinds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_kind != KIND_DATA) |=> !$rose(irq_flag));
    p_last_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && remain == REM_W'(1) && !rem_load) |=> (remain == '0));
    p_arm_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !irx_en && ff_arm) |=> !ff_arm);
endmodule

// File: tb/test_i2c_irx_path.sv
`timescale 1ns/1ps
module test_i2c_irx_path;
    logic clk = 1'b0, rst_n = 1'b0;
    logic byte_done = 0, is_master = 0, tx_pop = 0, reg_wr = 0, reg_rd = 0;
    logic [1:0] byte_kind = 0;
    logic [7:0] byte_data = 0, reg_wdata = 0, reg_rdata, tx_data;
    logic [2:0] reg_addr = 0;
    logic irq_flag, scl_hold, nack_next, tx_dma_req, rx_dma_req;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    i2c_irx_path i_i2c_irx_path (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_kind(byte_kind),
        .byte_data(byte_data), .is_master(is_master), .tx_pop(tx_pop),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_flag(irq_flag), .scl_hold(scl_hold),
        .nack_next(nack_next), .tx_data(tx_data), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req)
    );

    // fill_rx, rx_thr, fill_tx, tx_thr (4 bits each)
    localparam logic [15:0] VEC [6] = '{
        16'h0_1_0_0, 16'h1_1_2_1, 16'h3_4_4_4,
        16'h8_8_8_7, 16'h5_2_1_3, 16'h2_3_3_2
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        cyc();
        rst_n = 1;
        cyc();
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        cyc();
        reg_rd = 0;
    endtask

    task automatic rx_byte(logic [1:0] k, logic [7:0] d);
        byte_done = 1; byte_kind = k; byte_data = d;
        cyc();
        byte_done = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 flag", {7'b0, irq_flag}, 8'h00);
        check("R1 hold", {7'b0, scl_hold}, 8'h00);
        check("R1 nack", {7'b0, nack_next}, 8'h00);
        check("R1 rx_req", {7'b0, rx_dma_req}, 8'h00);
        check("R1 tx_req", {7'b0, tx_dma_req}, 8'h01);
        rd(3'd1, v); check("R1 ctrl", v, 8'h00);

        // R9 R10 threshold table
        for (int i = 0; i < 6; i++) begin
            logic [3:0] frx, trx, ftx, ttx;
            {frx, trx, ftx, ttx} = VEC[i];
            do_reset();
            wr(3'd3, {ttx, trx});
            for (int j = 0; j < frx; j++) rx_byte(2'd1, 8'(j));
            for (int j = 0; j < ftx; j++) wr(3'd0, 8'(8'h40 + j));
            check("R10 rx_req", {7'b0, rx_dma_req}, {7'b0, frx >= trx});
            check("R9 tx_req", {7'b0, tx_dma_req}, {7'b0, ftx <= ttx});
        end
        // R9 pop lowers count
        do_reset();
        wr(3'd3, 8'h10);
        wr(3'd0, 8'hA1); wr(3'd0, 8'hA2);
        check("R9 head", tx_data, 8'hA1);
        check("R9 req off", {7'b0, tx_dma_req}, 8'h00);
        tx_pop = 1; cyc(); tx_pop = 0;
        check("R9 req on", {7'b0, tx_dma_req}, 8'h01);

        // R2 R3 R4 interactive byte
        do_reset();
        wr(3'd1, 8'h01);
        rx_byte(2'd1, 8'h5C);
        check("R2 flag", {7'b0, irq_flag}, 8'h01);
        check("R2 hold", {7'b0, scl_hold}, 8'h01);
        check("R2 no fifo", {7'b0, rx_dma_req}, 8'h00);
        rd(3'd0, v); check("R3 held", v, 8'h5C);
        wr(3'd2, 8'h00);
        check("R4 w0", {7'b0, irq_flag}, 8'h01);
        wr(3'd2, 8'h01);
        check("R4 cleared", {7'b0, irq_flag}, 8'h00);
        check("R4 hold late", {7'b0, scl_hold}, 8'h01);
        cyc();
        check("R4 released", {7'b0, scl_hold}, 8'h00);
        // byte was read, so leaving the mode reads empty FIFO
        wr(3'd1, 8'h00);
        rd(3'd0, v); check("R2 fifo empty", v, 8'h00);

        // R5 other kinds
        do_reset();
        wr(3'd1, 8'h01);
        rx_byte(2'd0, 8'hA0); rx_byte(2'd2, 8'h00); rx_byte(2'd3, 8'h01);
        check("R5 flag", {7'b0, irq_flag}, 8'h00);
        check("R5 hold", {7'b0, scl_hold}, 8'h00);
        wr(3'd1, 8'h00);
        rd(3'd0, v); check("R5 not stored", v, 8'h00);

        // R6 unread byte gives 0xFF once
        do_reset();
        wr(3'd1, 8'h01);
        rx_byte(2'd1, 8'h37);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h01);
        rd(3'd0, v); check("R6 ff", v, 8'hFF);
        rd(3'd0, v); check("R6 once", v, 8'h00);
        // R7 underflow bit
        rd(3'd2, v); check("R7 underflow", v, 8'h02);
        wr(3'd2, 8'h02);
        rd(3'd2, v); check("R7 uf clear", v, 8'h00);

        // R7 R8 switch mid-transfer in master mode
        do_reset();
        is_master = 1;
        wr(3'd1, 8'h01);
        rx_byte(2'd1, 8'hA5);
        rd(3'd0, v); check("R3 cmd", v, 8'hA5);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h02);
        check("R8 nack2", {7'b0, nack_next}, 8'h00);
        wr(3'd2, 8'h01);
        cyc();
        rx_byte(2'd1, 8'h11);
        check("R8 nack1", {7'b0, nack_next}, 8'h01);
        rx_byte(2'd1, 8'h22);
        check("R8 nack0", {7'b0, nack_next}, 8'h00);
        rd(3'd4, v); check("R8 remain", v, 8'h00);
        rd(3'd0, v); check("R7 order1", v, 8'h11);
        rd(3'd0, v); check("R7 order2", v, 8'h22);
        rd(3'd0, v); check("R7 empty", v, 8'h00);
        // R8 load ignored as slave
        is_master = 0;
        wr(3'd4, 8'h05);
        rd(3'd4, v); check("R8 slave load", v, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule